// File: doc/BRIEF.md
# Interlocked Strobe Bus Master

This block is the processor-facing end of an asynchronous memory bus. Each request from the processor side starts exactly one read or one write cycle. The cycle uses a separate address strobe and data strobe and a fully interlocked four-phase handshake with the slave's acknowledge. The master steps through a fixed sequence of bus states, with at least one clock per step. It waits for as long as the slave needs, and it reports completion with a single-clock done pulse once the slave has withdrawn its acknowledge.

The acknowledge comes from an unrelated timing domain, so it passes through a synchronizer before the state machine acts on it. An optional wait timer raises a flag when the slave is slow to answer. The timer does not abort the cycle. The states are IDLE, ADDR, ASTB, RWSET, DSTB, RELDS, RELAS and DONE. The transitions are:

- IDLE to ADDR when a request arrives.
- ADDR to ASTB to RWSET to DSTB, one clock each.
- DSTB to RELDS once the synchronized acknowledge is high.
- RELDS to RELAS, always.
- RELAS to DONE once the synchronized acknowledge is low.
- DONE to IDLE, always.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset, bus_as_o, bus_ds_o, done_o and timeout_o are 0, and bus_rw_o rests at 1.
- R2: A request is taken only in the idle state. On the clock after acceptance, bus_addr_o carries the requested address while bus_as_o is still 0. bus_as_o rises one clock later, and the address stays stable for the whole time bus_as_o is high.
- R3: bus_rw_o stays at 1 when bus_as_o rises. One clock later it takes the request's direction (1 = read, 0 = write), and it stays stable while bus_ds_o is high.
- R4: In a write, bus_wdata_o carries the request's write data one clock before bus_ds_o rises, and it holds that data while bus_ds_o is high.
- R5: bus_ds_o rises two clocks after bus_as_o and is only ever high while bus_as_o is high. It stays high until the acknowledge has been seen through the two-flop synchronizer, so it falls 3 clocks after bus_ack_i rises. In a read, bus_rdata_i is captured at that same edge.
- R6: bus_as_o falls exactly one clock after bus_ds_o falls, never before it.
- R7: The cycle is not complete while bus_ack_i is high. done_o appears 3 clocks after bus_ack_i falls, however long the slave holds its acknowledge.
- R8: done_o is high for a single clock. For a read, rdata_o then carries the data that the slave presented.
- R9: Requests made while a cycle is in progress are ignored. They change neither the address on the bus nor the number of cycles run, and they do not start a new cycle after done.
- R10: With a nonzero tmo_limit_i of L, timeout_o rises L clocks after bus_ds_o rises if the synchronized acknowledge has not yet been seen (that is, when L is at most the acknowledge delay plus 2). It stays set, it never rises when L is 0, and it clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a bus cycle (sampled in idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Target address |
| wdata_i | input | DW | Write data |
| tmo_limit_i | input | TW | Timeout limit in clocks, 0 disables |
| rdata_o | output | DW | Last captured read data |
| done_o | output | 1 | One-clock completion pulse |
| timeout_o | output | 1 | Sticky slow-slave flag |
| bus_addr_o | output | AW | Bus address lines |
| bus_as_o | output | 1 | Address strobe, high = address valid |
| bus_rw_o | output | 1 | Direction line, high = read |
| bus_ds_o | output | 1 | Data strobe |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_ack_i | input | 1 | Slave data acknowledge |

## Verification
The bench uses an acknowledge that arrives on the first clock of the data strobe. A master that skipped the synchronizer, or that fell through the wait state, would drop the data strobe early and show the wrong release timing. The bench also holds the acknowledge long after both strobes have fallen; a design that ended the cycle on the strobe release rather than on the acknowledge drop would pulse done too soon. Other runs keep the request line asserted through a whole cycle, which catches a master that accepts outside idle or restarts right after done. The timer limit is varied against the acknowledge delay, including one clock and zero, which exposes off-by-one expiry and a disabled timer that still fires.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ASTB,
        ST_RWSET,
        ST_DSTB,
        ST_RELDS,
        ST_RELAS,
        ST_DONE
    } sbm_state_e;

endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbm_wait_timer.sv
module sbm_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            expired <= 1'b0;
        end else if (clear) begin
            expired <= 1'b0;
        end else if (run && (limit != '0) && (cnt == limit - 1'b1)) begin
            expired <= 1'b1;
        end
    end
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
    import sbm_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int TW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] tmo_limit_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_as_o,
    output logic          bus_rw_o,
    output logic          bus_ds_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_ack_i
);
    sbm_state_e    state_q, state_d;
    logic          ack_s;
    logic          accept;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          dir_phase;

    sbm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ack_i),
        .q     (ack_s)
    );

    sbm_wait_timer #(.TW(TW)) u_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     ((state_q == ST_DSTB) && !ack_s),
        .limit   (tmo_limit_i),
        .expired (timeout_o)
    );

    assign accept = (state_q == ST_IDLE) && req_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_ASTB;
            ST_ASTB:  state_d = ST_RWSET;
            ST_RWSET: state_d = ST_DSTB;
            ST_DSTB:  if (ack_s) state_d = ST_RELDS;
            ST_RELDS: state_d = ST_RELAS;
            ST_RELAS: if (!ack_s) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b1;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                rd_q    <= rd_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end
            if ((state_q == ST_DSTB) && ack_s && rd_q) begin
                rdata_q <= bus_rdata_i;
            end
        end
    end

    // outputs
    always_comb begin
        dir_phase   = (state_q == ST_RWSET) || (state_q == ST_DSTB) ||
                      (state_q == ST_RELDS) || (state_q == ST_RELAS);
        bus_addr_o  = addr_q;
        bus_as_o    = (state_q == ST_ASTB) || (state_q == ST_RWSET) ||
                      (state_q == ST_DSTB) || (state_q == ST_RELDS);
        bus_ds_o    = (state_q == ST_DSTB);
        bus_rw_o    = dir_phase ? rd_q : 1'b1;
        bus_wdata_o = (dir_phase && !rd_q) ? wdata_q : '0;
        done_o      = (state_q == ST_DONE);
        rdata_o     = rdata_q;
    end
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_as_o,
    input logic          bus_rw_o,
    input logic          bus_ds_o,
    input logic [DW-1:0] bus_wdata_o,
    input logic          bus_ack_i
);
    a_r2_addr_stable_under_as: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_o |-> $stable(bus_addr_o));

    a_r3_rw_stable_under_ds: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds_o |-> $stable(bus_rw_o));

    a_r3_rw_idle_at_as_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as_o) |-> bus_rw_o);

    a_r4_wdata_ready_before_ds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ds_o) && !bus_rw_o) |-> $stable(bus_wdata_o));

    a_r5_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds_o |-> bus_as_o);

    a_r6_as_falls_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as_o) |-> (!bus_ds_o && !$past(bus_ds_o)));

    a_r7_done_after_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!bus_ack_i && !$past(bus_ack_i)));

    a_r8_done_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_with_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!bus_as_o && !bus_ds_o));
endmodule

bind strobe_bus_master sbm_checker #(.AW(AW), .DW(DW)) u_sbm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .bus_addr_o  (bus_addr_o),
    .bus_as_o    (bus_as_o),
    .bus_rw_o    (bus_rw_o),
    .bus_ds_o    (bus_ds_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/strobe_bus_master_tb.sv
module strobe_bus_master_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          rd_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [TW-1:0] tmo_limit_i = '0;
    logic [DW-1:0] rdata_o;
    logic          done_o, timeout_o;
    logic [AW-1:0] bus_addr_o;
    logic          bus_as_o, bus_rw_o, bus_ds_o;
    logic [DW-1:0] bus_wdata_o;
    logic [DW-1:0] bus_rdata_i = '0;
    logic          bus_ack_i = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [DW-1:0] last_rdata = '0;

    always #2 clk = ~clk;

    strobe_bus_master #(.AW(AW), .DW(DW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rd_i(rd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .tmo_limit_i(tmo_limit_i), .rdata_o(rdata_o),
        .done_o(done_o), .timeout_o(timeout_o), .bus_addr_o(bus_addr_o),
        .bus_as_o(bus_as_o), .bus_rw_o(bus_rw_o), .bus_ds_o(bus_ds_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_timeout(input int lim, input int ack_dly);
        return (lim != 0) && (lim <= ack_dly + 2);
    endfunction

    task automatic run_txn(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input int ack_dly, input int rel_dly, input bit poke, input int lim);
        int cyc = 0;
        int as_rise = -1, ds_rise = -1, ack_rise = -1, ds_fall = -1, drop = -1, tmo_at = -1;
        int rel_cnt = 0;
        bit prev_as = 1'b0, prev_ds = 1'b0, acked = 1'b0, done_seen = 1'b0;
        logic [DW-1:0] rv = DW'($urandom);
        tmo_limit_i = TW'(lim);
        req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = wd;
        @(negedge clk);
        req_i = poke;
        chk(bus_addr_o == a && !bus_as_o, "R2 address before strobe", bus_addr_o, a);
        chk(!timeout_o, "R10 flag cleared on accept", timeout_o, 0);
        while (!done_seen && cyc < 3000) begin
            if (bus_as_o && !prev_as) begin
                as_rise = cyc;
                chk(as_rise == 1, "R2 strobe one clock after address", as_rise, 1);
                chk(bus_rw_o == 1'b1, "R3 rw idle at strobe rise", bus_rw_o, 1);
            end
            if (as_rise >= 0 && cyc == as_rise + 1)
                chk(bus_rw_o == rd, "R3 direction set", bus_rw_o, rd);
            if (!rd && as_rise >= 0 && cyc == as_rise + 1)
                chk(bus_wdata_o == wd, "R4 write data before ds", bus_wdata_o, wd);
            if (bus_as_o)
                chk(bus_addr_o == a, "R9 address unaffected", bus_addr_o, a);
            if (bus_ds_o && !prev_ds) begin
                ds_rise = cyc;
                chk(ds_rise == as_rise + 2, "R5 ds two clocks after as", ds_rise, as_rise + 2);
            end
            if (bus_ds_o && !rd)
                chk(bus_wdata_o == wd, "R4 write data held", bus_wdata_o, wd);
            if (!bus_ds_o && prev_ds) begin
                ds_fall = cyc;
                chk(ds_fall == ack_rise + 3, "R5 ds release after synced ack", ds_fall, ack_rise + 3);
                chk(bus_as_o, "R6 as still high at ds fall", bus_as_o, 1);
            end
            if (!bus_as_o && prev_as)
                chk(ds_fall >= 0 && cyc == ds_fall + 1, "R6 as one clock after ds", cyc, ds_fall + 1);
            if (timeout_o && tmo_at < 0) begin
                tmo_at = cyc;
                chk(ds_rise >= 0 && cyc - ds_rise == lim, "R10 timeout clock", cyc - ds_rise, lim);
            end
            if (done_o) begin
                done_seen = 1'b1;
                req_i = 1'b0;
                chk(drop >= 0 && cyc == drop + 3, "R7 done after ack drop", cyc, drop + 3);
                if (rd) begin
                    chk(rdata_o == rv, "R8 read data", rdata_o, rv);
                    last_rdata = rv;
                end else begin
                    chk(rdata_o == last_rdata, "R8 write keeps read data", rdata_o, last_rdata);
                end
            end
            // slave behaviour
            if (bus_ds_o && !acked && ds_rise >= 0 && cyc - ds_rise == ack_dly) begin
                acked = 1'b1; bus_ack_i = 1'b1; bus_rdata_i = rv; ack_rise = cyc;
            end else if (bus_ack_i && !bus_ds_o && ds_fall >= 0) begin
                if (rel_cnt == rel_dly) begin
                    bus_ack_i = 1'b0; drop = cyc;
                end else begin
                    rel_cnt++;
                end
            end
            if (poke && !done_seen) begin
                req_i = 1'b1; addr_i = AW'($urandom); rd_i = ~rd;
            end
            prev_as = bus_as_o; prev_ds = bus_ds_o;
            @(negedge clk);
            cyc++;
        end
        chk(done_seen, "R7 cycle completes", done_seen, 1);
        chk(!done_o, "R8 done one clock", done_o, 0);
        chk(tmo_at >= 0 == exp_timeout(lim, ack_dly), "R10 timeout outcome", tmo_at >= 0, exp_timeout(lim, ack_dly));
        chk(timeout_o == exp_timeout(lim, ack_dly), "R10 flag sticky", timeout_o, exp_timeout(lim, ack_dly));
        @(negedge clk);
        chk(!bus_as_o && !done_o, "R9 no cycle from ignored request", bus_as_o, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!bus_as_o && !bus_ds_o && !done_o && !timeout_o && bus_rw_o, "R1 reset values",
            {bus_as_o, bus_ds_o, done_o, timeout_o, bus_rw_o}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_as_o && bus_rw_o, "R1 idle after reset", bus_as_o, 0);
        // directed corners
        run_txn(1'b1, 16'h1234, 16'h0, 0, 0, 1'b0, 0);      // R5 immediate ack
        run_txn(1'b0, 16'hBEEF, 16'hA5C3, 2, 20, 1'b0, 0);  // R7 long ack hold
        run_txn(1'b1, 16'h0F0F, 16'h0, 30, 1, 1'b0, 1);     // R10 limit of one
        run_txn(1'b1, 16'h0F10, 16'h0, 30, 1, 1'b0, 0);     // R10 disabled
        run_txn(1'b0, 16'h7777, 16'h1111, 5, 3, 1'b1, 7);   // R9 request held, R10 at edge
        run_txn(1'b1, 16'h8888, 16'h0, 5, 3, 1'b1, 8);      // R10 just beyond
        for (int i = 0; i < 40; i++) begin
            run_txn(1'($urandom), AW'($urandom), DW'($urandom), int'($urandom_range(0, 15)),
                    int'($urandom_range(0, 6)), 1'($urandom), int'($urandom_range(0, 12)));
        end
        finish_run();
    end
endmodule